// File: doc/BRIEF.md
# Single-Pass Device Identifier Search Sequencer

This block performs one pass of the bus search that a single-wire master uses to find one device's 64-bit identifier among several devices on a shared line. A pass is started with a one-cycle strobe. With the strobe, the caller supplies two values from the preceding pass: the identifier it returned and the conflict position it reported. At the end of the pass the block reports a new identifier, a new conflict position and a completion status. The caller runs passes one after another, feeding each pass's outputs into the next, until the reported conflict position is zero. Each pass yields a different device.

The block does not time the line itself. It hands each line operation to a separate slot engine through a request/acknowledge pair. An operation is either a bus reset with presence sampling, or a single bit slot with a bit to write and a sampled bit that comes back. Every pass runs in a fixed order. First comes a reset. Next the search command byte goes out, least significant bit first. Then, for every identifier bit, the block runs three slots: it reads the bit, reads its complement, and writes back the bit it chose.

At a conflict, where both reads return 0, the block picks a direction with a compact rule. The rule compares the remaining bit index with the previous conflict position and looks at the previous identifier bit. When it picks 1 this way, it records that index as the new conflict position.

Top module: `owsrch_seq`

## Requirements
- R1: A start strobe while the block is idle makes the next line operation a reset request (`op_reset`=1). Later operations are bit slots (`op_reset`=0). `op_req` is a one-cycle pulse, and each request waits for one `op_ack` before the next request is issued.
- R2: For a reset, `op_rbit`=1 on the acknowledge means a presence response was seen. If it is 0, the pass ends at once with `done` and `status`=1 (no presence), and no further request is issued.
- R3: After a reset that saw presence, the command byte 0xF0 is sent as 8 bit slots, least significant bit first. Each slot's `op_wbit` carries one command bit.
- R4: For each identifier bit, the block issues two read slots with `op_wbit`=1. The first samples the bit and the second samples its complement. A write slot carrying the chosen bit follows.
- R5: If both reads of a bit return 1, the pass ends with `done` and `status`=2 (data error). No write slot is issued for that bit, and no later request is issued.
- R6: Bit indices run from ID_BITS down to 1. When both reads return 0, the chosen bit is 1 in two cases: the previous conflict position is greater than the index, or the previous identifier bit at this position is 1 and the index differs from the previous conflict position. In either case the index becomes the new conflict position. Otherwise at a conflict the chosen bit is 0.
- R7: When the two reads differ, the chosen bit equals the first read.
- R8: The new conflict position starts each pass at 0 and keeps the last index recorded under R6. A first pass uses 0xFF as its previous conflict position. A completed pass with `next_disc`=0 means the last device was found.
- R9: The bit handled n-th in a pass (n from 0) is written at `new_id[n]`. Each byte therefore holds its first-handled bit in its least significant position. The previous identifier bit used under R6 is `prev_id[n]`.
- R10: `done` is a single-cycle pulse. `status` is encoded 0 ok, 1 no presence, 2 data error. `status`, `new_id` and `next_disc` hold from `done` until the next pass ends. A start strobe during a pass is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle strobe that begins a pass when idle |
| prev_disc | input | DISC_W | Conflict position from the previous pass (0xFF on a first pass) |
| prev_id | input | ID_BITS | Identifier from the previous pass |
| done | output | 1 | One-cycle pulse at the end of a pass |
| status | output | 2 | 0 ok, 1 no presence, 2 data error |
| new_id | output | ID_BITS | Identifier found by the pass |
| next_disc | output | DISC_W | New conflict position, 0 for the last device |
| op_req | output | 1 | One-cycle request for a line operation |
| op_reset | output | 1 | 1: the request is a bus reset; 0: a bit slot |
| op_wbit | output | 1 | Bit to write in a bit slot |
| op_ack | input | 1 | Slot engine reports the requested operation finished |
| op_rbit | input | 1 | Sampled line bit, or presence flag for a reset |

## Verification
The bench builds the block with a 16-bit identifier and an 8-bit conflict position. This keeps a pass short enough that whole device populations can be enumerated pass by pass, including a population of sixteen devices that covers every combination of the low four bits. It models wired-AND devices at slot level and compares each pass against a reference search computed in the bench. Populations differing only in the first-handled or last-handled bit reach both ends of the index range. An empty bus, an injected both-ones read and a start strobe during a pass reach the abort and ignore paths.

// File: rtl/owsrch_pkg.sv
package owsrch_pkg;
   typedef enum logic [1:0] {
      SRCH_OK      = 2'd0,
      SRCH_NOPRES  = 2'd1,
      SRCH_DATAERR = 2'd2
   } srch_status_e;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_RESET = 3'd1,
      PH_CMD   = 3'd2,
      PH_RDA   = 3'd3,
      PH_RDB   = 3'd4,
      PH_WR    = 3'd5
   } srch_phase_e;
endpackage

// File: rtl/owsrch_pick.sv
module owsrch_pick #(
   parameter int DISC_W = 8
) (
   input  logic              rd_a,
   input  logic              rd_b,
   input  logic [DISC_W-1:0] idx,
   input  logic [DISC_W-1:0] prev_disc,
   input  logic              prev_bit,
   output logic              pick,
   output logic              record,
   output logic              bad
);
   logic conflict;
   logic take_one;

   always_comb begin
      bad      = rd_a & rd_b;
      conflict = ~rd_a & ~rd_b;
      take_one = conflict & ((prev_disc > idx) | (prev_bit & (prev_disc != idx)));
      pick     = conflict ? take_one : rd_a;
      record   = take_one;
   end
endmodule

// File: rtl/owsrch_cmdser.sv
module owsrch_cmdser #(
   parameter int                CMD_W    = 8,
   parameter logic [CMD_W-1:0]  CMD_CODE = 8'hF0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic step,
   output logic bit_o,
   output logic last
);
   localparam int CNT_W = (CMD_W > 1) ? $clog2(CMD_W) : 1;

   logic [CMD_W-1:0] sh_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (load) begin
         sh_q  <= CMD_CODE;
         cnt_q <= '0;
      end else if (step) begin
         sh_q  <= sh_q >> 1;
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign bit_o = sh_q[0];
   assign last  = (cnt_q == CNT_W'(CMD_W - 1));
endmodule

// File: rtl/owsrch_idreg.sv
module owsrch_idreg #(
   parameter int ID_BITS = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [ID_BITS-1:0] load_val,
   input  logic               shift,
   input  logic               din,
   output logic               head,
   output logic [ID_BITS-1:0] id_q
);
   localparam int NBYTES = ID_BITS / 8;

   logic [ID_BITS-1:0] nxt;

   // Byte lanes: each lane shifts right, its top bit fed by the lane above;
   // the top lane takes the new bit. Unloads oldest bit at the bottom.
   for (genvar g = 0; g < NBYTES; g++) begin : g_lane
      if (g == NBYTES - 1) begin : g_top
         assign nxt[8*g+7] = din;
      end else begin : g_mid
         assign nxt[8*g+7] = id_q[8*(g+1)];
      end
      assign nxt[8*g+6 -: 7] = id_q[8*g+7 -: 7];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     id_q <= '0;
      else if (load)  id_q <= load_val;
      else if (shift) id_q <= nxt;
   end

   assign head = id_q[0];
endmodule

// File: rtl/owsrch_seq.sv
module owsrch_seq
   import owsrch_pkg::*;
#(
   parameter int               ID_BITS  = 64,
   parameter int               DISC_W   = 8,
   parameter int               CMD_W    = 8,
   parameter logic [CMD_W-1:0] CMD_CODE = 8'hF0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [DISC_W-1:0]  prev_disc,
   input  logic [ID_BITS-1:0] prev_id,
   output logic               done,
   output logic [1:0]         status,
   output logic [ID_BITS-1:0] new_id,
   output logic [DISC_W-1:0]  next_disc,
   output logic               op_req,
   output logic               op_reset,
   output logic               op_wbit,
   input  logic               op_ack,
   input  logic               op_rbit
);
   localparam logic [DISC_W-1:0] IDX_TOP = DISC_W'(ID_BITS);
   localparam logic [DISC_W-1:0] IDX_END = DISC_W'(1);

   initial begin
      assert (ID_BITS % 8 == 0 && ID_BITS >= 8)
         else $error("ID_BITS must be a positive multiple of 8");
      assert ((2 ** DISC_W) > ID_BITS)
         else $error("DISC_W too narrow for ID_BITS");
      assert (CMD_W >= 1)
         else $error("CMD_W must be at least 1");
   end

   srch_phase_e        phase_q;
   logic               wait_q;
   logic [DISC_W-1:0]  idx_q, pdisc_q, ndisc_q, nxt_disc_q;
   logic               rda_q, pick_q, done_q;
   srch_status_e       status_q;
   logic [ID_BITS-1:0] new_id_q;

   logic ack_ev, id_load, id_shift, cmd_step;
   logic cmd_bit, cmd_last;
   logic id_head;
   logic [ID_BITS-1:0] id_cur;
   logic pick, record, bad;

   assign ack_ev   = wait_q & op_ack & (phase_q != PH_IDLE);
   assign id_load  = (phase_q == PH_IDLE) & start;
   assign id_shift = ack_ev & (phase_q == PH_RDB) & ~bad;
   assign cmd_step = ack_ev & (phase_q == PH_CMD);

   owsrch_cmdser #(.CMD_W(CMD_W), .CMD_CODE(CMD_CODE)) u_cmd (
      .clk(clk), .rst_n(rst_n), .load(id_load), .step(cmd_step),
      .bit_o(cmd_bit), .last(cmd_last)
   );

   owsrch_idreg #(.ID_BITS(ID_BITS)) u_id (
      .clk(clk), .rst_n(rst_n), .load(id_load), .load_val(prev_id),
      .shift(id_shift), .din(pick), .head(id_head), .id_q(id_cur)
   );

   owsrch_pick #(.DISC_W(DISC_W)) u_pick (
      .rd_a(rda_q), .rd_b(op_rbit), .idx(idx_q), .prev_disc(pdisc_q),
      .prev_bit(id_head), .pick(pick), .record(record), .bad(bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         wait_q     <= 1'b0;
         idx_q      <= '0;
         pdisc_q    <= '0;
         ndisc_q    <= '0;
         nxt_disc_q <= '0;
         rda_q      <= 1'b0;
         pick_q     <= 1'b0;
         done_q     <= 1'b0;
         status_q   <= SRCH_OK;
         new_id_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (phase_q == PH_IDLE) begin
            if (start) begin
               phase_q <= PH_RESET;
               wait_q  <= 1'b0;
               pdisc_q <= prev_disc;
               ndisc_q <= '0;
               idx_q   <= IDX_TOP;
            end
         end else if (!wait_q) begin
            wait_q <= 1'b1;
         end else if (op_ack) begin
            wait_q <= 1'b0;
            unique case (phase_q)
               PH_RESET: begin
                  if (op_rbit) phase_q <= PH_CMD;
                  else begin
                     phase_q  <= PH_IDLE;
                     done_q   <= 1'b1;
                     status_q <= SRCH_NOPRES;
                  end
               end
               PH_CMD: if (cmd_last) phase_q <= PH_RDA;
               PH_RDA: begin
                  rda_q   <= op_rbit;
                  phase_q <= PH_RDB;
               end
               PH_RDB: begin
                  if (bad) begin
                     phase_q  <= PH_IDLE;
                     done_q   <= 1'b1;
                     status_q <= SRCH_DATAERR;
                  end else begin
                     pick_q  <= pick;
                     if (record) ndisc_q <= idx_q;
                     phase_q <= PH_WR;
                  end
               end
               PH_WR: begin
                  if (idx_q == IDX_END) begin
                     phase_q    <= PH_IDLE;
                     done_q     <= 1'b1;
                     status_q   <= SRCH_OK;
                     new_id_q   <= id_cur;
                     nxt_disc_q <= ndisc_q;
                  end else begin
                     idx_q   <= idx_q - 1'b1;
                     phase_q <= PH_RDA;
                  end
               end
               default: phase_q <= PH_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      op_req   = (phase_q != PH_IDLE) & ~wait_q;
      op_reset = (phase_q == PH_RESET);
      unique case (phase_q)
         PH_CMD:  op_wbit = cmd_bit;
         PH_WR:   op_wbit = pick_q;
         default: op_wbit = 1'b1;
      endcase
   end

   assign done      = done_q;
   assign status    = status_q;
   assign new_id    = new_id_q;
   assign next_disc = nxt_disc_q;

   AST_START_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_IDLE && start) |=> (op_req && op_reset)); // R1
   AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      op_req |=> !op_req); // R1
   AST_NOPRES_END: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_ev && phase_q == PH_RESET && !op_rbit) |=> (done && status == 2'd1 && !op_req)); // R2
   AST_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (op_req && (phase_q == PH_RDA || phase_q == PH_RDB)) |-> op_wbit); // R4
   AST_ERR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_ev && phase_q == PH_RDB && rda_q && op_rbit) |=> (done && status == 2'd2 && !op_req)); // R5
   AST_FIRST_READ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_req && phase_q == PH_WR && rda_q) |-> op_wbit); // R7
   AST_DISC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == 2'd0) |-> (next_disc <= IDX_TOP)); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && $stable(new_id) && $stable(status))); // R10
endmodule

// File: tb/tb_owsrch_seq.sv
module tb_owsrch_seq;
   localparam int CLK_PERIOD = 10;
   localparam int IDB = 16;
   localparam int DW  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [DW-1:0] prev_disc = '0;
   logic [IDB-1:0] prev_id = '0;
   logic done;
   logic [1:0] status;
   logic [IDB-1:0] new_id;
   logic [DW-1:0] next_disc;
   logic op_req, op_reset, op_wbit;
   logic op_ack = 1'b0;
   logic op_rbit = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   owsrch_seq #(.ID_BITS(IDB), .DISC_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .prev_disc(prev_disc),
      .prev_id(prev_id), .done(done), .status(status), .new_id(new_id),
      .next_disc(next_disc), .op_req(op_req), .op_reset(op_reset),
      .op_wbit(op_wbit), .op_ack(op_ack), .op_rbit(op_rbit)
   );

   int nchk = 0;
   int nerr = 0;
   logic [IDB-1:0] dev [16];
   int ndev = 0;
   int err_at = -1;
   bit exp_reset = 1'b0;
   int nslot = 0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // slot-level bus model: wired-AND of the devices still in the search
   initial begin : responder
      logic [15:0] act;
      logic [7:0]  cmdv;
      int cmdc, ph, trip, bitn, lat;
      logic resp, a, b, kind, wb;
      act = '0; cmdv = '0; cmdc = 0; ph = 0; trip = 0; bitn = 0;
      forever begin
         @(negedge clk);
         while (op_req) begin
            nslot++;
            kind = op_reset;
            wb   = op_wbit;
            if (exp_reset) begin
               check(kind == 1'b1, "R1 first op is reset", 32'(kind), 32'd1);
               exp_reset = 1'b0;
            end
            resp = 1'b1;
            if (kind) begin
               resp = (ndev > 0);
               act = '0;
               for (int d = 0; d < ndev; d++) act[d] = 1'b1;
               ph = 1; cmdc = 0; cmdv = '0;
            end else if (ph == 1) begin
               cmdv = {wb, cmdv[7:1]};
               cmdc++;
               if (cmdc == 8) begin
                  check(cmdv == 8'hF0, "R3 command byte", 32'(cmdv), 32'hF0);
                  ph = 2; trip = 0; bitn = 0;
               end
            end else begin
               if (trip < 2) begin
                  check(wb == 1'b1, "R4 read slot writes one", 32'(wb), 32'd1);
                  a = 1'b1; b = 1'b1;
                  for (int d = 0; d < ndev; d++)
                     if (act[d]) begin a &= dev[d][bitn]; b &= ~dev[d][bitn]; end
                  if (bitn == err_at) begin a = 1'b1; b = 1'b1; end
                  resp = (trip == 0) ? a : b;
                  trip++;
               end else begin
                  for (int d = 0; d < ndev; d++)
                     if (dev[d][bitn] != wb) act[d] = 1'b0;
                  trip = 0;
                  bitn++;
               end
            end
            lat = kind ? 3 : 1;
            repeat (lat) @(negedge clk);
            op_rbit = resp;
            op_ack  = 1'b1;
            @(negedge clk);
            op_ack  = 1'b0;
            op_rbit = 1'b0;
         end
      end
   end

   task automatic ref_pass(input logic [IDB-1:0] pid, input logic [DW-1:0] pd,
                           output logic [IDB-1:0] rid, output logic [DW-1:0] rd,
                           output logic [1:0] rs);
      logic [15:0] act;
      logic a, b, c;
      logic [DW-1:0] idx;
      rid = '0; rd = '0; rs = 2'd0;
      if (ndev == 0) begin rs = 2'd1; return; end
      act = '0;
      for (int d = 0; d < ndev; d++) act[d] = 1'b1;
      for (int n = 0; n < IDB; n++) begin
         idx = DW'(IDB - n);
         a = 1'b1; b = 1'b1;
         for (int d = 0; d < ndev; d++)
            if (act[d]) begin a &= dev[d][n]; b &= ~dev[d][n]; end
         if (n == err_at) begin a = 1'b1; b = 1'b1; end
         if (a && b) begin rs = 2'd2; return; end
         if (!a && !b) begin
            c = (pd > idx) || (pid[n] && pd != idx);
            if (c) rd = idx;
         end else c = a;
         rid[n] = c;
         for (int d = 0; d < ndev; d++)
            if (dev[d][n] != c) act[d] = 1'b0;
      end
   endtask

   task automatic run_pass(input logic [IDB-1:0] pid, input logic [DW-1:0] pd, input bit poke,
                           output logic [IDB-1:0] gid, output logic [DW-1:0] gd, output logic [1:0] gs);
      int cnt, snap;
      @(negedge clk);
      prev_id = pid; prev_disc = pd; start = 1'b1; exp_reset = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cnt = 0;
      while (!done && cnt < 5000) begin
         if (poke && cnt == 20) begin
            prev_id = ~pid; prev_disc = 8'hFF; start = 1'b1;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         cnt++;
      end
      start = 1'b0;
      if (cnt >= 5000) check(1'b0, "R10 done timeout", 32'(cnt), 32'd0);
      gid = new_id; gd = next_disc; gs = status;
      snap = nslot;
      repeat (30) @(negedge clk);
      check(nslot == snap, "R10 no request after done", 32'(nslot), 32'(snap));
      check(new_id == gid && status == gs, "R10 outputs held", 32'(new_id), 32'(gid));
   endtask

   task automatic enumerate(input string name);
      logic [IDB-1:0] pid, gid, eid;
      logic [DW-1:0] pd, gd, ed;
      logic [1:0] gs, es;
      logic [15:0] found;
      int passes;
      pid = '0; pd = 8'hFF; found = '0; passes = 0;
      do begin
         ref_pass(pid, pd, eid, ed, es);
         run_pass(pid, pd, 1'b0, gid, gd, gs);
         passes++;
         check(gs == es, "R7 status of pass", 32'(gs), 32'(es));
         check(gid == eid, "R9 identifier", 32'(gid), 32'(eid));
         check(gd == ed, "R6 next conflict position", 32'(gd), 32'(ed));
         for (int d = 0; d < ndev; d++) if (dev[d] == gid) found[d] = 1'b1;
         pid = gid; pd = gd;
      end while (gd != 0 && gs == 2'd0 && passes <= ndev + 1);
      check($countones(found) == ndev && passes == ndev, "R8 every device once, last code 0",
            32'(passes), 32'(ndev));
      $display("set %s: %0d passes", name, passes);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin : main
      logic [IDB-1:0] gid, eid;
      logic [DW-1:0] gd, ed;
      logic [1:0] gs, es;
      repeat (3) @(negedge clk);
      check(done == 1'b0 && op_req == 1'b0, "R10 reset state idle", 32'({done, op_req}), 32'd0);
      check(status == 2'd0 && next_disc == 0, "R10 reset outputs", 32'(status), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R9: single device comes back bit for bit
      ndev = 1; dev[0] = 16'h00A5;
      run_pass('0, 8'hFF, 1'b0, gid, gd, gs);
      check(gid == 16'h00A5, "R9 single device id", 32'(gid), 32'h00A5);
      check(gd == 0 && gs == 2'd0, "R8 single device is last", 32'(gd), 32'd0);

      // R6 / R8: conflict at the last-handled bit (index 1)
      ndev = 2; dev[0] = 16'h1234; dev[1] = 16'h9234;
      run_pass('0, 8'hFF, 1'b0, gid, gd, gs);
      check(gid == 16'h9234 && gd == 8'd1, "R6 conflict takes one", 32'(gid), 32'h9234);
      run_pass(gid, gd, 1'b0, gid, gd, gs);
      check(gid == 16'h1234 && gd == 8'd0, "R6 index equal takes zero", 32'(gid), 32'h1234);

      // conflict at the first-handled bit (index 16)
      dev[0] = 16'h0001; dev[1] = 16'h0000;
      enumerate("first-bit");
      ndev = 4; dev[0] = 16'h0F0F; dev[1] = 16'h0F0E; dev[2] = 16'hF0F0; dev[3] = 16'h8F0F;
      enumerate("four");
      ndev = 8;
      for (int i = 0; i < 8; i++) dev[i] = IDB'(i * 16'h2F1D) ^ 16'h5A3C;
      enumerate("eight");
      ndev = 16;
      for (int i = 0; i < 16; i++) dev[i] = 16'h7700 | IDB'(i);
      enumerate("low-nibble sweep");

      // R2: empty bus
      ndev = 0;
      run_pass('0, 8'hFF, 1'b0, gid, gd, gs);
      check(gs == 2'd1, "R2 no presence status", 32'(gs), 32'd1);

      // R5: both reads one at several bit positions
      ndev = 4; dev[0] = 16'h0F0F; dev[1] = 16'h0F0E; dev[2] = 16'hF0F0; dev[3] = 16'h8F0F;
      for (int k = 0; k < IDB; k += 5) begin
         err_at = k;
         run_pass('0, 8'hFF, 1'b0, gid, gd, gs);
         check(gs == 2'd2, "R5 data error status", 32'(gs), 32'd2);
      end
      err_at = -1;

      // R10: start during a pass is ignored
      ref_pass(16'h0F0E, 8'd3, eid, ed, es);
      run_pass(16'h0F0E, 8'd3, 1'b1, gid, gd, gs);
      check(gid == eid && gd == ed && gs == es, "R10 start ignored while busy", 32'(gid), 32'(eid));

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule